// File: doc/BRIEF.md
# Multi-Slice External Event Timestamp Unit

The unit holds a bank of independent capture slices. Each slice picks one line out of a wide bus of external event inputs. It passes that line through a two-stage synchronizer and watches for a low-to-high transition. On each qualifying transition it stores a snapshot of two timebases that arrive as input buses. One is a 64-bit time-of-day value, read as a seconds word and a nanoseconds word. The other is a 64-bit free-running global tick count whose low eight bits are a fraction below one tick. Each timebase has its own capture enable.

Snapshots go into a small per-slice FIFO. Software reaches the FIFO through a word-addressed register port. Each slice has eight word slots: configuration, status, the head entry's four capture words, the head entry's event kind, and a command slot that either pops the head entry or flushes the whole FIFO. A per-slice interrupt line is high while the FIFO holds data and the slice's interrupt enable is set. Captures that arrive while the FIFO is full are dropped, and a sticky overflow flag records the loss.

Top module: `ets_unit`

## Requirements
- R1: After reset, every configuration and status word reads zero and every interrupt output is low.
- R2: A slice captures when configuration bit 0 is set, the selected line goes high and at least one timebase enable is set. The entry holds the bus values sampled on the third rising clock edge after the line rises (two synchronizer stages plus one edge register).
- R3: A slice ignores three kinds of stimulus: a transition on any line other than the one chosen by configuration bits 9:4, a high-to-low transition, and any transition while configuration bit 0 is clear.
- R4: Configuration bit 17 enables time-of-day capture and bit 16 enables global-count capture. A disabled timebase reads zero in the entry. With both enables clear, no entry is made.
- R5: The event-kind word has three fields. Bit 0 is set when time-of-day was captured. Bit 1 is set when the global count was captured. Bits 9:4 hold the line select that was active at capture.
- R6: Word addresses are {slice, slot}, with slot 0 configuration, 1 status, 2 time-of-day low (nanoseconds), 3 time-of-day high (seconds), 4 global low, 5 global high, 6 event kind and 7 command. Read data appears one clock after the address. Configuration bits other than 0, 9:4, 16, 17 and 31 read zero.
- R7: Each FIFO holds 4 entries and returns them oldest first. Writing 0x1 to the command slot removes the head entry.
- R8: A capture that arrives while the FIFO holds 4 entries is dropped. Stored entries are unchanged, and status bit 4 (overflow) sets and stays set through pops.
- R9: Writing 0x7 to the command slot empties the FIFO and clears the overflow flag.
- R10: A slice's interrupt output is high one clock after its FIFO is non-empty while configuration bit 31 is set, and low otherwise.
- R11: The status word has four fields. Bit 0 is set when the FIFO is non-empty. Bits 3:1 hold the entry count. Bit 4 is the overflow flag. Bit 5 is set when the FIFO is full. Higher bits read zero.
- R12: Slices are independent. Two slices that select the same line capture the same values from one transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_in | input | NEV | External event lines, asynchronous |
| tod_in | input | 64 | Time-of-day bus, seconds in upper word |
| gct_in | input | 64 | Global tick count, low 8 bits fractional |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | SLICE_AW+3 | Word address {slice, slot} |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | NSLICE | Per-slice interrupt |

## Verification
The bench checks the exact capture cycle by giving both timebases a value that changes every clock. A synchronizer that is one stage too short or too long therefore returns the wrong snapshot. It drives a fifth event into a full FIFO and then drains it. A design that overwrote the oldest entry would return the wrong first value, and one that dropped the sticky flag would show a clean status. It fires unselected lines, falling edges and events with both enables clear. A slice that reacted to any of these would show a non-zero count. It also separates pop from flush, and masks the interrupt on one of two slices that share a line, so that a crossed decode or a missing enable shows up at the ports.

// File: rtl/ets_pkg.sv
package ets_pkg;
  localparam int TS_W   = 64;
  localparam int KIND_W = 8;
  localparam int SLOT_W = 3;

  typedef enum logic [SLOT_W-1:0] {
    SLOT_CFG    = 3'd0,
    SLOT_STAT   = 3'd1,
    SLOT_TOD_LO = 3'd2,
    SLOT_TOD_HI = 3'd3,
    SLOT_GCT_LO = 3'd4,
    SLOT_GCT_HI = 3'd5,
    SLOT_KIND   = 3'd6,
    SLOT_CMD    = 3'd7
  } slot_e;

  localparam int CFG_RISE    = 0;
  localparam int CFG_SEL_LSB = 4;
  localparam int CFG_GCT_EN  = 16;
  localparam int CFG_TOD_EN  = 17;
  localparam int CFG_IRQ_EN  = 31;

  localparam logic [31:0] CMD_POP   = 32'h1;
  localparam logic [31:0] CMD_FLUSH = 32'h7;

  typedef struct packed {
    logic [TS_W-1:0]   tod;
    logic [TS_W-1:0]   gct;
    logic [KIND_W-1:0] kind;
  } cap_t;
endpackage

// File: rtl/ets_edge_sync.sv
module ets_edge_sync #(
  parameter int NEV   = 64,
  parameter int SEL_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NEV-1:0]   ev_in,
  input  logic [SEL_W-1:0] sel,
  output logic             rise
);
  logic picked;
  logic sync_a, sync_b, prev;

  assign picked = ev_in[sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
      prev   <= 1'b0;
    end else begin
      sync_a <= picked;
      sync_b <= sync_a;
      prev   <= sync_b;
    end
  end

  assign rise = sync_b & ~prev;
endmodule

// File: rtl/ets_fifo.sv
module ets_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty,
  output logic             ovf
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic             push_ok, pop_ok;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push & ~full & ~flush;
  assign pop_ok  = pop & ~empty & ~flush;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (push_ok) wp <= nxt(wp);
      if (pop_ok)  rp <= nxt(rp);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push & full) ovf <= 1'b1;
    end
  end

  assign dout = mem[rp];
endmodule

// File: rtl/ets_slice.sv
module ets_slice
  import ets_pkg::*;
#(
  parameter int NEV   = 64,
  parameter int SEL_W = 6,
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NEV-1:0]   ev_in,
  input  logic [TS_W-1:0]  tod_in,
  input  logic [TS_W-1:0]  gct_in,
  input  logic             cfg_we,
  input  logic             cmd_we,
  input  logic [31:0]      wdata,
  output logic [31:0]      cfg_o,
  output logic [31:0]      stat_o,
  output cap_t             head_o,
  output logic             irq_o,
  output logic             push_o,
  output logic             flush_o,
  output logic             nempty_o,
  output logic             full_o,
  output logic             ovf_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [31:0] SEL_MASK = ((32'h1 << SEL_W) - 32'h1) << CFG_SEL_LSB;
  localparam logic [31:0] CFG_MASK = (32'h1 << CFG_RISE) | SEL_MASK |
                                     (32'h1 << CFG_GCT_EN) | (32'h1 << CFG_TOD_EN) |
                                     (32'h1 << CFG_IRQ_EN);

  logic [31:0]      cfg;
  logic [SEL_W-1:0] sel;
  logic             rise, empty, pop;
  cap_t             entry;

  always_ff @(posedge clk) begin
    if (rst)         cfg <= '0;
    else if (cfg_we) cfg <= wdata & CFG_MASK;
  end

  assign sel = cfg[CFG_SEL_LSB +: SEL_W];

  ets_edge_sync #(.NEV(NEV), .SEL_W(SEL_W)) u_sync (
    .clk(clk), .rst(rst), .ev_in(ev_in), .sel(sel), .rise(rise)
  );

  assign push_o  = rise & cfg[CFG_RISE] & (cfg[CFG_GCT_EN] | cfg[CFG_TOD_EN]);
  assign flush_o = cmd_we & (wdata == CMD_FLUSH);
  assign pop     = cmd_we & (wdata == CMD_POP);

  always_comb begin
    entry.tod  = cfg[CFG_TOD_EN] ? tod_in : '0;
    entry.gct  = cfg[CFG_GCT_EN] ? gct_in : '0;
    entry.kind = '0;
    entry.kind[0] = cfg[CFG_TOD_EN];
    entry.kind[1] = cfg[CFG_GCT_EN];
    entry.kind[KIND_W-1:2] = (KIND_W-2)'(sel);
  end

  ets_fifo #(.W($bits(cap_t)), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push_o), .pop(pop), .flush(flush_o),
    .din(entry), .dout(head_o), .count(cnt_o), .full(full_o),
    .empty(empty), .ovf(ovf_o)
  );

  assign nempty_o = ~empty;

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= cfg[CFG_IRQ_EN] & ~empty;
  end

  assign cfg_o  = cfg;
  assign stat_o = {26'd0, full_o, ovf_o, 3'(cnt_o), ~empty};
endmodule

// File: rtl/ets_unit.sv
module ets_unit
  import ets_pkg::*;
#(
  parameter int NSLICE = 4,
  parameter int NEV    = 64,
  parameter int DEPTH  = 4,
  localparam int SEL_W    = $clog2(NEV),
  localparam int SLICE_AW = $clog2(NSLICE),
  localparam int ADDR_W   = SLICE_AW + SLOT_W,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NEV-1:0]    ev_in,
  input  logic [63:0]       tod_in,
  input  logic [63:0]       gct_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [NSLICE-1:0] irq
);
  logic [SLICE_AW-1:0] a_slice;
  slot_e               a_slot;

  logic [31:0] cfg_a  [NSLICE];
  logic [31:0] stat_a [NSLICE];
  cap_t        head_a [NSLICE];

  logic [NSLICE-1:0]            ie_v, ne_v, full_v, ovf_v, flush_v, push_v;
  logic [NSLICE-1:0][CNT_W-1:0] cnt_v;

  assign a_slice = reg_addr[ADDR_W-1:SLOT_W];
  assign a_slot  = slot_e'(reg_addr[SLOT_W-1:0]);

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    logic cfg_we, cmd_we;
    assign cfg_we = reg_wr && (a_slice == SLICE_AW'(s)) && (a_slot == SLOT_CFG);
    assign cmd_we = reg_wr && (a_slice == SLICE_AW'(s)) && (a_slot == SLOT_CMD);

    ets_slice #(.NEV(NEV), .SEL_W(SEL_W), .DEPTH(DEPTH)) u_slice (
      .clk(clk), .rst(rst), .ev_in(ev_in), .tod_in(tod_in), .gct_in(gct_in),
      .cfg_we(cfg_we), .cmd_we(cmd_we), .wdata(reg_wdata),
      .cfg_o(cfg_a[s]), .stat_o(stat_a[s]), .head_o(head_a[s]), .irq_o(irq[s]),
      .push_o(push_v[s]), .flush_o(flush_v[s]), .nempty_o(ne_v[s]),
      .full_o(full_v[s]), .ovf_o(ovf_v[s]), .cnt_o(cnt_v[s])
    );

    assign ie_v[s] = cfg_a[s][CFG_IRQ_EN];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (a_slot)
        SLOT_CFG:    reg_rdata <= cfg_a[a_slice];
        SLOT_STAT:   reg_rdata <= stat_a[a_slice];
        SLOT_TOD_LO: reg_rdata <= head_a[a_slice].tod[31:0];
        SLOT_TOD_HI: reg_rdata <= head_a[a_slice].tod[63:32];
        SLOT_GCT_LO: reg_rdata <= head_a[a_slice].gct[31:0];
        SLOT_GCT_HI: reg_rdata <= head_a[a_slice].gct[63:32];
        SLOT_KIND:   reg_rdata <= {22'd0, head_a[a_slice].kind[7:2], 2'b00,
                                   head_a[a_slice].kind[1:0]};
        default:     reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/ets_unit_chk.sv
module ets_unit_chk #(
  parameter int NSLICE = 4,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic                            clk,
  input logic                            rst,
  input logic [NSLICE-1:0]               irq,
  input logic [NSLICE-1:0]               ie_v,
  input logic [NSLICE-1:0]               ne_v,
  input logic [NSLICE-1:0]               full_v,
  input logic [NSLICE-1:0]               ovf_v,
  input logic [NSLICE-1:0]               flush_v,
  input logic [NSLICE-1:0]               push_v,
  input logic [NSLICE-1:0][CNT_W-1:0]    cnt_v
);
  assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> (irq == '0));

  for (genvar s = 0; s < NSLICE; s++) begin : g_chk
    assert_depth_bound_R7: assert property (@(posedge clk) disable iff (rst)
      cnt_v[s] <= CNT_W'(DEPTH));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
      $rose(ovf_v[s]) |-> $past(full_v[s] & push_v[s]));

    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (rst)
      flush_v[s] |=> (cnt_v[s] == '0) && !ovf_v[s]);

    assert_irq_follows_R10: assert property (@(posedge clk) disable iff (rst)
      irq[s] |-> $past(ie_v[s] & ne_v[s]));

    assert_full_nonempty_R11: assert property (@(posedge clk) disable iff (rst)
      full_v[s] |-> ne_v[s]);
  end
endmodule

bind ets_unit ets_unit_chk #(.NSLICE(NSLICE), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .ie_v(ie_v), .ne_v(ne_v), .full_v(full_v),
  .ovf_v(ovf_v), .flush_v(flush_v), .push_v(push_v), .cnt_v(cnt_v)
);

// File: tb/ets_unit_bench.sv
module ets_unit_bench;
  localparam int NSL = 4;
  localparam int NEV = 64;

  typedef struct {
    logic [63:0] tod;
    logic [63:0] gct;
    logic [31:0] kind;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [NEV-1:0] ev_in = '0;
  logic [63:0] tod_in, gct_in;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NSL-1:0] irq;

  int unsigned tcount = 0;
  int n_chk = 0, n_err = 0;
  bit finished = 0;

  item_t       exp_q [NSL][$];
  logic [31:0] sh_cfg [NSL];
  int          sh_cnt [NSL];
  bit          sh_ovf [NSL];

  always #4 clk = ~clk;
  always @(negedge clk) tcount <= tcount + 1;

  function automatic logic [63:0] tod_f(int unsigned n);
    return {32'h0000_0100 + n, n * 32'd7};
  endfunction
  function automatic logic [63:0] gct_f(int unsigned n);
    return {32'hA000_0000 + n, n[23:0], 8'h3C};
  endfunction

  assign tod_in = tod_f(tcount);
  assign gct_in = gct_f(tcount);

  ets_unit u_ets_unit (
    .clk(clk), .rst(rst), .ev_in(ev_in), .tod_in(tod_in), .gct_in(gct_in),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int s, int slot, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 5'((s << 3) | slot); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(int s, int slot, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 5'((s << 3) | slot);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic set_cfg(int s, logic [31:0] v);
    wr(s, 0, v);
    sh_cfg[s] = v;
  endtask

  task automatic flush(int s);
    wr(s, 7, 32'h7);
    sh_cnt[s] = 0; sh_ovf[s] = 0;
    exp_q[s].delete();
  endtask

  // driver: raise a line, predict captures into the scoreboard
  task automatic fire(int e);
    int unsigned k;
    @(negedge clk); #1;
    k = tcount;
    ev_in[e] = 1'b1;
    for (int s = 0; s < NSL; s++) begin
      logic [31:0] c;
      c = sh_cfg[s];
      if (c[0] && (int'(c[9:4]) == e) && (c[16] || c[17])) begin
        if (sh_cnt[s] < 4) begin
          item_t it;
          it.tod  = c[17] ? tod_f(k + 2) : 64'd0;
          it.gct  = c[16] ? gct_f(k + 2) : 64'd0;
          it.kind = {22'd0, c[9:4], 2'b00, c[16], c[17]};
          exp_q[s].push_back(it);
          sh_cnt[s]++;
        end else begin
          sh_ovf[s] = 1;
        end
      end
    end
    repeat (4) @(negedge clk);
    ev_in[e] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_stat(int s, string tag);
    logic [31:0] d, e;
    rd(s, 1, d);
    e = {26'd0, 1'(sh_cnt[s] == 4), sh_ovf[s], 3'(sh_cnt[s]), 1'(sh_cnt[s] != 0)};
    check(tag, d, e);
  endtask

  // monitor: read head entry, pop scoreboard, compare, then pop the design
  task automatic drain(int s, string tag);
    logic [31:0] tl, th, gl, gh, kd;
    item_t it;
    rd(s, 2, tl); rd(s, 3, th); rd(s, 4, gl); rd(s, 5, gh); rd(s, 6, kd);
    if (exp_q[s].size() == 0) begin
      n_chk++; n_err++;
      $display("FAIL %s actual=entry expected=none", tag);
    end else begin
      it = exp_q[s].pop_front();
      check({tag, " tod"},  {th, tl}, it.tod);
      check({tag, " gct"},  {gh, gl}, it.gct);
      check({tag, " kind"}, {32'd0, kd}, {32'd0, it.kind});
    end
    wr(s, 7, 32'h1);
    if (sh_cnt[s] > 0) sh_cnt[s]--;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int s = 0; s < NSL; s++) begin sh_cfg[s] = 0; sh_cnt[s] = 0; sh_ovf[s] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(0, 0, d); check("R1 cfg", d, 0);
    rd(2, 1, d); check("R1 stat", d, 0);
    check("R1 irq", irq, 0);

    // R6 config readback with undefined bits masked
    set_cfg(0, 32'hFFFF_FFFF);
    rd(0, 0, d); check("R6 cfg mask", d, 32'h8003_03F1);
    set_cfg(0, 32'h8003_0051);  // sel 5, rise, both enables, irq

    // R2 basic capture, R10 irq, R11 status
    fire(5);
    check("R10 irq set", irq[0], 1);
    check_stat(0, "R11 one entry");
    drain(0, "R2 capture");
    check_stat(0, "R7 after pop");
    @(negedge clk);
    check("R10 irq clear", irq[0], 0);

    // R3 ignored stimuli
    fire(6);
    check_stat(0, "R3 other line");
    set_cfg(0, 32'h8003_0050);
    fire(5);
    check_stat(0, "R3 rise disabled");
    check("R3 irq stays low", irq[0], 0);

    // R4 per-timebase enables, R5 kind
    set_cfg(0, 32'h8002_0091);  // sel 9, tod only
    fire(9);
    drain(0, "R4 tod only");
    set_cfg(0, 32'h0001_0091);  // gct only, irq off
    fire(9);
    check("R10 irq masked", irq[0], 0);
    drain(0, "R5 gct only");
    set_cfg(0, 32'h8000_0091);  // neither enable
    fire(9);
    check_stat(0, "R4 both off");

    // R7 ordering, R8 overflow
    set_cfg(0, 32'h8003_0031);  // sel 3
    for (int i = 0; i < 5; i++) fire(3);
    check_stat(0, "R8 full+ovf");
    for (int i = 0; i < 4; i++) drain(0, "R7 order");
    check_stat(0, "R8 ovf sticky");

    // R9 flush
    fire(3); fire(3);
    check_stat(0, "R9 pre flush");
    flush(0);
    check_stat(0, "R9 flushed");
    rd(0, 0, d); check("R9 cfg kept", d, 32'h8003_0031);

    // R12 two slices on one line, one masked
    set_cfg(1, 32'h8003_0071);  // sel 7
    set_cfg(2, 32'h0003_0071);  // sel 7, irq off
    fire(7);
    check("R12 irq slice1", irq[1], 1);
    check("R12 irq slice2 masked", irq[2], 0);
    check_stat(0, "R12 slice0 untouched");
    drain(1, "R12 slice1");
    drain(2, "R12 slice2");
    check_stat(3, "R12 slice3 idle");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule